// File: doc/BRIEF.md
# Peripheral Request Front End

This block sits in front of one transfer channel. Eight peripheral request lines come in. A small configuration word picks one of them and says how to read it: by level or by edge, and which polarity counts. The block then raises a single transfer request towards the transfer engine. It also sends handshake signals back to the peripheral. These are a per-line acknowledge and a per-line terminal-count strobe, and only the selected line ever sees them.

The engine reports three things: each read unit, each write unit, and the last unit of a transfer. The configuration decides how acknowledge follows these reports. Acknowledge can follow the read side or the write side. It can be a one-clock pulse, it can be held while the request stays active, or it can be suppressed. Terminal count marks the final unit unless it is masked. All request lines are synchronised before they are used. All outputs come straight from flip-flops.

Top module: `dreq_frontend`

## Requirements
- R1: `cfg_sel` (binary line index) routes the block to one line. Bit `cfg_sel` of `ack_o` and of `tc_o` is the only bit that may go high. Every other bit stays 0, and lines that are not selected never create a request.
- R2: The request lines pass through two synchroniser flip-flops. In level mode, a change on the selected line reaches `xfer_req_o` on the third rising edge after the change is driven.
- R3: With `cfg_level`=1, the request is active while the synchronised line is high and `cfg_hi_en`=1, or while it is low and `cfg_lo_en`=1. With both enables at 0, `xfer_req_o` stays 0.
- R4: With `cfg_level`=0, `cfg_hi_en` accepts rising edges and `cfg_lo_en` accepts falling edges. A detected edge sets `xfer_req_o`. It stays set until a clock edge where `eng_accept_i`=1 and no new edge is detected. An edge seen in the same cycle as the accept keeps the request set.
- R5: `cfg_ack_mode` selects how acknowledge behaves. With 2'b00, each unit event gives a one-clock acknowledge on the next clock. With 2'b01, acknowledge rises one clock after a unit event and holds as long as the selected request stays active per R3. With 2'b10 or 2'b11, acknowledge stays 0.
- R6: A unit event is `eng_rd_i` when `cfg_dst_side`=0 and `eng_wr_i` when `cfg_dst_side`=1. The engine strobe of the other side has no effect on acknowledge or terminal count.
- R7: When `cfg_tc_mask`=1, `tc_o` stays 0.
- R8: A unit event with `eng_last_i`=1 pulses `tc_o` on the selected line for exactly one clock. The pulse comes on the next clock, in the same cycle as the pulse-mode acknowledge for that unit.
- R9: While `rst` is high, and on the first clock after it, `xfer_req_o`, `ack_o` and `tc_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 3 | Index of the request line in use |
| cfg_level | input | 1 | 1: level sensing, 0: edge sensing |
| cfg_hi_en | input | 1 | Accept a high level or rising edge |
| cfg_lo_en | input | 1 | Accept a low level or falling edge |
| cfg_ack_mode | input | 2 | 00 pulse, 01 follow request, 1x off |
| cfg_dst_side | input | 1 | 0: acknowledge on read, 1: on write |
| cfg_tc_mask | input | 1 | 1 suppresses terminal count |
| dreq_i | input | 8 | Asynchronous peripheral request lines |
| eng_accept_i | input | 1 | Engine takes the pending request |
| eng_rd_i | input | 1 | Engine performed a read unit |
| eng_wr_i | input | 1 | Engine performed a write unit |
| eng_last_i | input | 1 | Current unit is the last of the transfer |
| xfer_req_o | output | 1 | Transfer request to the engine |
| ack_o | output | 8 | Per-line acknowledge |
| tc_o | output | 8 | Per-line terminal-count strobe |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a new edge and an engine accept. The bench drives random accepts while the selected line toggles in edge mode, so some edges land on the exact accept cycle, and it checks that the request survives them. The second pair is the last-unit terminal count and the acknowledge pulse. Random last flags are mixed with read and write strobes, and both outputs are compared every clock against a behavioural model. That comparison shows the two strobes share one cycle and one line.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    ACK_PULSE  = 2'b00,
    ACK_FOLLOW = 2'b01,
    ACK_OFF0   = 2'b10,
    ACK_OFF1   = 2'b11
  } ack_mode_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int N_LINES = 8,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] d_i,
  output logic [N_LINES-1:0] sync_o,
  output logic [N_LINES-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;
  logic [N_LINES-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign sync_o = stg[STAGES-1];
  assign prev_o = stg[STAGES];
endmodule

// File: rtl/dreq_detect.sv
module dreq_detect (
  input  logic clk,
  input  logic rst,
  input  logic cur_i,
  input  logic prev_i,
  input  logic level_i,
  input  logic hi_en_i,
  input  logic lo_en_i,
  input  logic accept_i,
  output logic hit_o,
  output logic req_o
);
  logic edge_seen;
  logic req_q;

  assign hit_o     = (hi_en_i & cur_i) | (lo_en_i & ~cur_i);
  assign edge_seen = (hi_en_i & cur_i & ~prev_i) | (lo_en_i & ~cur_i & prev_i);

  always_ff @(posedge clk) begin
    if (rst)          req_q <= 1'b0;
    else if (level_i) req_q <= hit_o;
    else              req_q <= edge_seen | (req_q & ~accept_i);
  end

  assign req_o = req_q;
endmodule

// File: rtl/dack_gen.sv
module dack_gen
  import dreq_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int SEL_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [1:0]         ack_mode_i,
  input  logic               dst_side_i,
  input  logic               tc_mask_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               last_i,
  input  logic               hit_i,
  output logic [N_LINES-1:0] ack_o,
  output logic [N_LINES-1:0] tc_o
);
  logic unit_ev;
  logic hold_q, hold_n;
  logic ack_on, tc_on;
  logic [N_LINES-1:0] ack_q, tc_q;
  ack_mode_e mode;

  assign mode    = ack_mode_e'(ack_mode_i);
  assign unit_ev = dst_side_i ? wr_i : rd_i;
  assign hold_n  = unit_ev | (hold_q & hit_i);
  assign tc_on   = unit_ev & last_i & ~tc_mask_i;

  always_comb begin
    case (mode)
      ACK_PULSE:  ack_on = unit_ev;
      ACK_FOLLOW: ack_on = hold_n;
      default:    ack_on = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= hold_n;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        ack_q[g] <= 1'b0;
        tc_q[g]  <= 1'b0;
      end else begin
        ack_q[g] <= ack_on & (sel_i == SEL_W'(g));
        tc_q[g]  <= tc_on  & (sel_i == SEL_W'(g));
      end
    end
  end

  assign ack_o = ack_q;
  assign tc_o  = tc_q;
endmodule

// File: rtl/dreq_frontend.sv
module dreq_frontend #(
  parameter int N_LINES = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic               cfg_level,
  input  logic               cfg_hi_en,
  input  logic               cfg_lo_en,
  input  logic [1:0]         cfg_ack_mode,
  input  logic               cfg_dst_side,
  input  logic               cfg_tc_mask,
  input  logic [N_LINES-1:0] dreq_i,
  input  logic               eng_accept_i,
  input  logic               eng_rd_i,
  input  logic               eng_wr_i,
  input  logic               eng_last_i,
  output logic               xfer_req_o,
  output logic [N_LINES-1:0] ack_o,
  output logic [N_LINES-1:0] tc_o
);
  logic [N_LINES-1:0] line_sync, line_prev;
  logic sel_cur, sel_prev, sel_hit;

  dreq_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(dreq_i), .sync_o(line_sync), .prev_o(line_prev)
  );

  assign sel_cur  = line_sync[cfg_sel];
  assign sel_prev = line_prev[cfg_sel];

  dreq_detect u_detect (
    .clk(clk), .rst(rst), .cur_i(sel_cur), .prev_i(sel_prev),
    .level_i(cfg_level), .hi_en_i(cfg_hi_en), .lo_en_i(cfg_lo_en),
    .accept_i(eng_accept_i), .hit_o(sel_hit), .req_o(xfer_req_o)
  );

  dack_gen #(.N_LINES(N_LINES)) u_ack (
    .clk(clk), .rst(rst), .sel_i(cfg_sel), .ack_mode_i(cfg_ack_mode),
    .dst_side_i(cfg_dst_side), .tc_mask_i(cfg_tc_mask),
    .rd_i(eng_rd_i), .wr_i(eng_wr_i), .last_i(eng_last_i),
    .hit_i(sel_hit), .ack_o(ack_o), .tc_o(tc_o)
  );
endmodule

// File: rtl/dreq_frontend_chk.sv
module dreq_frontend_chk #(
  parameter int N_LINES = 8,
  localparam int SEL_W = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst,
  input logic [SEL_W-1:0]   cfg_sel,
  input logic               cfg_level,
  input logic               cfg_hi_en,
  input logic               cfg_lo_en,
  input logic [1:0]         cfg_ack_mode,
  input logic               cfg_tc_mask,
  input logic               eng_accept_i,
  input logic               xfer_req_o,
  input logic [N_LINES-1:0] ack_o,
  input logic [N_LINES-1:0] tc_o
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  AST_ACK_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_o) && $onehot0(tc_o)); // R1

  AST_LEVEL_NO_POLARITY: assert property (@(posedge clk) disable iff (rst || was_rst)
    ($past(cfg_level) && !$past(cfg_hi_en) && !$past(cfg_lo_en)) |-> !xfer_req_o); // R3

  AST_EDGE_PENDING_HELD: assert property (@(posedge clk) disable iff (rst || was_rst)
    ($past(!cfg_level && xfer_req_o && !eng_accept_i)) |-> xfer_req_o); // R4

  AST_ACK_MASKED: assert property (@(posedge clk) disable iff (rst || was_rst)
    $past(cfg_ack_mode[1]) |-> (ack_o == '0)); // R5

  AST_TC_MASKED: assert property (@(posedge clk) disable iff (rst || was_rst)
    $past(cfg_tc_mask) |-> (tc_o == '0)); // R7

  AST_TC_WITH_ACK: assert property (@(posedge clk) disable iff (rst || was_rst)
    ((tc_o != '0) && ($past(cfg_ack_mode) == 2'b00)) |-> (tc_o == ack_o)); // R8
endmodule

bind dreq_frontend dreq_frontend_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_level(cfg_level),
  .cfg_hi_en(cfg_hi_en), .cfg_lo_en(cfg_lo_en), .cfg_ack_mode(cfg_ack_mode),
  .cfg_tc_mask(cfg_tc_mask), .eng_accept_i(eng_accept_i),
  .xfer_req_o(xfer_req_o), .ack_o(ack_o), .tc_o(tc_o)
);

// File: tb/dreq_frontend_tb.sv
module dreq_frontend_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] cfg_sel;
  logic       cfg_level, cfg_hi_en, cfg_lo_en, cfg_dst_side, cfg_tc_mask;
  logic [1:0] cfg_ack_mode;
  logic [7:0] dreq_i;
  logic       eng_accept_i, eng_rd_i, eng_wr_i, eng_last_i;
  logic       xfer_req_o;
  logic [7:0] ack_o, tc_o;

  int checks = 0;
  int errors = 0;
  string tag = "R9";
  int ack_ev_cnt = 0;
  int tc_cnt = 0;

  // behavioural model state
  int m_s1 [8], m_s2 [8], m_s3 [8];
  int m_req = 0, m_hold = 0, m_ack = 0, m_tc = 0;

  always #5 clk = ~clk;

  dreq_frontend u_dut (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_level(cfg_level),
    .cfg_hi_en(cfg_hi_en), .cfg_lo_en(cfg_lo_en), .cfg_ack_mode(cfg_ack_mode),
    .cfg_dst_side(cfg_dst_side), .cfg_tc_mask(cfg_tc_mask), .dreq_i(dreq_i),
    .eng_accept_i(eng_accept_i), .eng_rd_i(eng_rd_i), .eng_wr_i(eng_wr_i),
    .eng_last_i(eng_last_i), .xfer_req_o(xfer_req_o), .ack_o(ack_o), .tc_o(tc_o)
  );

  always @(posedge clk) begin
    int sel, cur, prv, hit, edg, ev, hold_n, ack_on;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; end
      m_req = 0; m_hold = 0; m_ack = 0; m_tc = 0;
    end else begin
      sel = int'(cfg_sel);
      cur = m_s2[sel];
      prv = m_s3[sel];
      hit = ((cfg_hi_en && cur == 1) || (cfg_lo_en && cur == 0)) ? 1 : 0;
      edg = ((cfg_hi_en && cur == 1 && prv == 0) || (cfg_lo_en && cur == 0 && prv == 1)) ? 1 : 0;
      if (cfg_level) m_req = hit;
      else m_req = (edg == 1 || (m_req == 1 && !eng_accept_i)) ? 1 : 0;
      ev = cfg_dst_side ? int'(eng_wr_i) : int'(eng_rd_i);
      hold_n = (ev == 1 || (m_hold == 1 && hit == 1)) ? 1 : 0;
      m_hold = hold_n;
      if (cfg_ack_mode == 2'b00) ack_on = ev;
      else if (cfg_ack_mode == 2'b01) ack_on = hold_n;
      else ack_on = 0;
      m_ack = ack_on ? (1 << sel) : 0;
      m_tc  = (ev == 1 && eng_last_i && !cfg_tc_mask) ? (1 << sel) : 0;
      for (int i = 0; i < 8; i++) begin
        m_s3[i] = m_s2[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = int'(dreq_i[i]);
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("xfer_req", int'(xfer_req_o), m_req);
    check("ack", int'(ack_o), m_ack);
    check("tc", int'(tc_o), m_tc);
    if (ack_o != 0) ack_ev_cnt++;
    if (tc_o != 0) tc_cnt++;
  endtask

  task automatic run(int cycles, int p_line, int p_eng);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_all();
      if (($urandom % 100) < p_line) dreq_i = dreq_i ^ (8'h1 << ($urandom % 8));
      eng_accept_i = (($urandom % 100) < 30);
      eng_rd_i     = (($urandom % 100) < p_eng);
      eng_wr_i     = (($urandom % 100) < p_eng);
      eng_last_i   = (($urandom % 100) < 40);
    end
  endtask

  task automatic cfg(input string t, input int sel, input bit lvl, input bit hi,
                     input bit lo, input int am, input bit dst, input bit tcm);
    @(negedge clk);
    compare_all();
    tag = t;
    cfg_sel = 3'(sel); cfg_level = lvl; cfg_hi_en = hi; cfg_lo_en = lo;
    cfg_ack_mode = 2'(am); cfg_dst_side = dst; cfg_tc_mask = tcm;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg_sel = 3'd0; cfg_level = 1'b1; cfg_hi_en = 1'b1; cfg_lo_en = 1'b0;
    cfg_ack_mode = 2'b00; cfg_dst_side = 1'b0; cfg_tc_mask = 1'b0;
    dreq_i = 8'h00; eng_accept_i = 0; eng_rd_i = 0; eng_wr_i = 0; eng_last_i = 0;
    repeat (3) @(negedge clk);
    // R9: outputs cleared in reset
    check("reset xfer_req", int'(xfer_req_o), 0);
    check("reset ack", int'(ack_o), 0);
    check("reset tc", int'(tc_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("post-reset ack", int'(ack_o), 0);

    // R2: directed latency check on line 3
    cfg("R2", 3, 1, 1, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    dreq_i = 8'h08;
    @(negedge clk); check("R2 after 1 edge", int'(xfer_req_o), 0);
    @(negedge clk); check("R2 after 2 edges", int'(xfer_req_o), 0);
    @(negedge clk); check("R2 after 3 edges", int'(xfer_req_o), 1);
    dreq_i = 8'h00;
    repeat (4) @(negedge clk);

    cfg("R3", 3, 1, 1, 0, 0, 0, 0);  run(300, 40, 20);
    cfg("R3", 5, 1, 0, 1, 0, 0, 0);  run(300, 40, 20);
    cfg("R3", 2, 1, 0, 0, 0, 0, 0);  run(200, 40, 20);
    cfg("R4", 1, 0, 1, 0, 0, 0, 0);  run(600, 50, 20);
    cfg("R4", 6, 0, 0, 1, 0, 0, 0);  run(600, 50, 20);
    cfg("R4", 0, 0, 1, 1, 0, 0, 0);  run(600, 50, 20);
    cfg("R5", 4, 1, 1, 0, 1, 0, 0);  run(600, 30, 15);
    cfg("R5", 4, 1, 0, 1, 1, 1, 0);  run(600, 30, 15);
    cfg("R5", 7, 1, 1, 0, 2, 0, 0);  run(300, 30, 40);
    cfg("R5", 7, 0, 1, 0, 3, 1, 0);  run(300, 30, 40);
    cfg("R6", 2, 1, 1, 0, 0, 1, 0);  run(600, 30, 30);
    cfg("R6", 2, 1, 1, 0, 0, 0, 0);  run(600, 30, 30);
    cfg("R7", 5, 1, 1, 0, 0, 0, 1);  run(400, 30, 40);
    cfg("R8", 3, 1, 1, 0, 0, 1, 0);  run(600, 30, 40);
    for (int s = 0; s < 8; s++) begin
      cfg("R1", s, s % 2, 1, s / 4, s % 2, s / 2 % 2, 0);
      run(200, 40, 30);
    end
    tag = "R8";
    check("some tc pulses seen", int'(tc_cnt > 0), 1);
    tag = "R5";
    check("some acks seen", int'(ack_ev_cnt > 0), 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule